// File: doc/BRIEF.md
# Multi-Source Programmable Clock Divider

This block produces the fast core clock of a larger chip. It picks one of five clock sources and divides that source by a ratio chosen from a small coded set. The sources are an external clock, three custom ring-oscillator clocks of different lengths and one ring oscillator built from standard cells. A single switch chooses between the external clock and an on-chip oscillator. A two-bit field chooses which oscillator is used, and a four-bit code chooses the division ratio.

The ratio set is not a ladder of powers of two. For the external clock and the three custom oscillators there are sixteen ratios, from 1 to 384, and several of them are multiples of three. For the standard-cell oscillator only six ratios are available. Odd ratios still give an even duty cycle. Ratio 1 passes the source through unchanged.

A change of source or ratio never puts a runt pulse on the output. The old source is released before the new one is admitted. The divider then holds its output low for a few cycles and restarts its counter from the beginning of a high phase. A monitor output carries a copy of the divided clock to an observation pin.

Top module: `clkdiv_top`

## Requirements
- R1: With `int_sel` = 0 the external clock `clk_ext` is the source, whatever the value of `osc_pick`.
- R2: With `int_sel` = 1, `osc_pick` values 0, 1 and 2 select `clk_osc7`, `clk_osc9` and `clk_osc11`, and value 3 selects `clk_sc`.
- R3: Exactly one source reaches the divider at a time. A source change never produces a high or low pulse on `clk_div` shorter than the shorter half-period of the old source and the new source.
- R4: For the external clock and the three custom oscillators, `div_code` values 0 to 15 give the ratios 1, 2, 3, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192 and 384, in that order.
- R5: For the standard-cell oscillator, `div_code` values 0 to 4 give the ratios 1, 2, 4, 8 and 16, and every value from 5 to 15 gives 128.
- R6: For an even ratio N, `clk_div` is high for N/2 source periods and low for N/2 source periods.
- R7: For an odd ratio N greater than 1, `clk_div` is high for N/2 source periods and low for N/2 source periods. Each phase ends on an opposite source edge.
- R8: With ratio 1, `clk_div` has the period and the high and low times of the selected source.
- R9: When the source or the ratio changes, the divider stops and holds `clk_div` low for at least two cycles of the new source. It then restarts with a full-length high phase.
- R10: While `rst_n` is low, `clk_div` and `clk_mon` are low, and an assertion of `rst_n` forces them low at once, without waiting for a clock.
- R11: `clk_mon` always carries the same value as `clk_div`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ext | input | 1 | External fast clock |
| clk_osc7 | input | 1 | Custom oscillator clock, shortest ring |
| clk_osc9 | input | 1 | Custom oscillator clock, middle ring |
| clk_osc11 | input | 1 | Custom oscillator clock, longest ring |
| clk_sc | input | 1 | Standard-cell oscillator clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| int_sel | input | 1 | 0: external clock, 1: internal oscillator |
| osc_pick | input | 2 | Internal oscillator choice (3 = standard-cell) |
| div_code | input | 4 | Division ratio code |
| clk_div | output | 1 | Divided core clock |
| clk_mon | output | 1 | Monitor copy of the divided clock |

## Verification
Two events can coincide: a reconfiguration can land while the divider is in the middle of a high phase of the old setting, so the source handover and the counter restart act on the same output pulse. The bench changes source and ratio at times that bear no relation to either clock's edges, including moves from ratio 1 to large ratios and back. A pulse-width monitor, running for the whole test, flags any output phase narrower than the fastest source half-period. After each change has settled, the high and low times are measured and compared with the product of the expected ratio and the expected source period, both computed by a behavioural reference model.

// File: rtl/cdiv_pkg.sv
// Package: shared constants, types and decode functions for the clock divider.
// Assumes five sources, indexed 0 = external, 1..3 = custom oscillators,
// 4 = standard-cell oscillator.
package cdiv_pkg;
    localparam int NSRC      = 5;
    localparam int SRC_W     = $clog2(NSRC);
    localparam int CODE_W    = 4;
    localparam int MAX_RATIO = 384;
    localparam int RATIO_W   = $clog2(MAX_RATIO + 1);

    localparam logic [SRC_W-1:0] SRC_EXT = SRC_W'(0);
    localparam logic [SRC_W-1:0] SRC_SC  = SRC_W'(NSRC - 1);

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic [CODE_W-1:0] code;
    } key_t;

    // Map the switch and oscillator field onto a source index.
    function automatic logic [SRC_W-1:0] pick_source(input logic int_sel,
                                                      input logic [1:0] osc_pick);
        if (!int_sel)
            return SRC_EXT;
        else if (osc_pick == 2'd3)
            return SRC_SC;
        else
            return SRC_W'(osc_pick) + SRC_W'(1);
    endfunction

    // Sixteen-entry ratio set for the external and custom oscillator sources.
    function automatic ratio_t wide_ratio(input logic [CODE_W-1:0] code);
        case (code)
            4'd0:    return ratio_t'(1);
            4'd1:    return ratio_t'(2);
            4'd2:    return ratio_t'(3);
            4'd3:    return ratio_t'(4);
            4'd4:    return ratio_t'(6);
            4'd5:    return ratio_t'(8);
            4'd6:    return ratio_t'(12);
            4'd7:    return ratio_t'(16);
            4'd8:    return ratio_t'(24);
            4'd9:    return ratio_t'(32);
            4'd10:   return ratio_t'(48);
            4'd11:   return ratio_t'(64);
            4'd12:   return ratio_t'(96);
            4'd13:   return ratio_t'(128);
            4'd14:   return ratio_t'(192);
            default: return ratio_t'(384);
        endcase
    endfunction

    // Reduced ratio set for the standard-cell oscillator; high codes saturate.
    function automatic ratio_t narrow_ratio(input logic [CODE_W-1:0] code);
        case (code)
            4'd0:    return ratio_t'(1);
            4'd1:    return ratio_t'(2);
            4'd2:    return ratio_t'(4);
            4'd3:    return ratio_t'(8);
            4'd4:    return ratio_t'(16);
            default: return ratio_t'(128);
        endcase
    endfunction

    // Ratio for a full configuration key.
    function automatic ratio_t key_ratio(input key_t k);
        return (k.src == SRC_SC) ? narrow_ratio(k.code) : wide_ratio(k.code);
    endfunction
endpackage

// File: rtl/clkdiv_src_switch.sv
// Module: glitch-free N-way clock selector.
// Each source has an arm flop on its rising edge and an enable flop on its
// falling edge. A source is armed only while no other source is enabled, so
// the old clock is released low before the new one is admitted.
// Assumes every source keeps toggling while it is being released or admitted.
module clkdiv_src_switch #(
    parameter int NSRC = 5
) (
    input  logic [NSRC-1:0] clk_in,
    input  logic            rst_n,
    input  logic [NSRC-1:0] want,
    output logic [NSRC-1:0] live,
    output logic            clk_out
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic arm_q;
        logic live_q;
        logic others;

        assign others = |(live & ~(NSRC'(1) << i));

        // Arm this source when requested and every other source is released.
        always_ff @(posedge clk_in[i] or negedge rst_n) begin
            if (!rst_n) arm_q <= 1'b0;
            else        arm_q <= want[i] & ~others;
        end

        // Enable or release on the falling edge, so the gate changes while the clock is low.
        always_ff @(negedge clk_in[i] or negedge rst_n) begin
            if (!rst_n) live_q <= 1'b0;
            else        live_q <= arm_q;
        end

        assign live[i] = live_q;
    end

    assign clk_out = |(clk_in & live);
endmodule

// File: rtl/clkdiv_core.sv
// Module: programmable divider running on the selected clock.
// It synchronises the configuration key and restarts on any change, holding
// the output low for HOLD cycles first. Even ratios come from one rising-edge
// phase flop. Odd ratios add a falling-edge copy to reach 50% duty. Ratio 1
// gates the clock through.
// Assumes the key is static for several clock cycles once it has changed.
module clkdiv_core
    import cdiv_pkg::*;
#(
    parameter int HOLD = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  key_t   key_raw,
    output logic   clk_div,
    output logic   running_o,
    output logic   restart_o,
    output ratio_t cnt_o,
    output ratio_t ratio_o
);
    localparam int HOLD_W = $clog2(HOLD + 1);

    key_t              key_s1, key_s2, key_cur;
    logic [HOLD_W-1:0] hold_q;
    logic              run_q, pos_q, neg_q, byp_q;
    ratio_t            cnt_q, ratio, half, cnt_nx;
    logic              odd, restart;

    // Decode the active ratio and the next counter value.
    always_comb begin
        ratio   = key_ratio(key_cur);
        half    = ratio >> 1;
        odd     = ratio[0] && (ratio != ratio_t'(1));
        cnt_nx  = (cnt_q == ratio - ratio_t'(1)) ? '0 : cnt_q + ratio_t'(1);
        restart = (key_s2 != key_cur);
    end

    // Bring the configuration key into this clock domain.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_s1 <= '0;
            key_s2 <= '0;
        end else begin
            key_s1 <= key_raw;
            key_s2 <= key_s1;
        end
    end

    // Restart control, counter and rising-edge phase flop.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_cur <= '0;
            hold_q  <= HOLD_W'(HOLD);
            run_q   <= 1'b0;
            cnt_q   <= '0;
            pos_q   <= 1'b0;
        end else if (restart) begin
            key_cur <= key_s2;
            hold_q  <= HOLD_W'(HOLD);
            run_q   <= 1'b0;
            cnt_q   <= '0;
            pos_q   <= 1'b0;
        end else if (!run_q) begin
            if (hold_q == '0) begin
                run_q <= 1'b1;
                cnt_q <= '0;
                pos_q <= (half != '0);
            end else begin
                hold_q <= hold_q - HOLD_W'(1);
            end
        end else begin
            cnt_q <= cnt_nx;
            pos_q <= (cnt_nx < half);
        end
    end

    // Falling-edge half-cycle extension for odd ratios and the bypass gate for ratio 1.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_q <= 1'b0;
            byp_q <= 1'b0;
        end else begin
            neg_q <= pos_q & odd;
            byp_q <= run_q & (ratio == ratio_t'(1));
        end
    end

    assign clk_div   = (clk & byp_q) | pos_q | neg_q;
    assign running_o = run_q;
    assign restart_o = restart;
    assign cnt_o     = cnt_q;
    assign ratio_o   = ratio;
endmodule

// File: rtl/clkdiv_top.sv
// Module: top of the multi-source programmable clock divider.
// Turns the switch and field inputs into a source request and a configuration
// key, selects the source glitch-free and divides it. The monitor pin is a
// plain copy of the divided clock.
// Assumes configuration inputs change rarely, with no relation to any clock.
module clkdiv_top
    import cdiv_pkg::*;
#(
    parameter int HOLD_CYC = 2
) (
    input  logic       clk_ext,
    input  logic       clk_osc7,
    input  logic       clk_osc9,
    input  logic       clk_osc11,
    input  logic       clk_sc,
    input  logic       rst_n,
    input  logic       int_sel,
    input  logic [1:0] osc_pick,
    input  logic [3:0] div_code,
    output logic       clk_div,
    output logic       clk_mon
);
    logic [SRC_W-1:0] src_idx;
    logic [NSRC-1:0]  want, live;
    logic             clk_mux;
    key_t             key_raw;
    logic             running, restart;
    ratio_t           cnt, ratio_cur;

    // Build the one-hot source request and the divider key.
    always_comb begin
        src_idx       = pick_source(int_sel, osc_pick);
        want          = '0;
        want[src_idx] = 1'b1;
        key_raw.src   = src_idx;
        key_raw.code  = div_code;
    end

    clkdiv_src_switch #(.NSRC(NSRC)) u_switch (
        .clk_in ({clk_sc, clk_osc11, clk_osc9, clk_osc7, clk_ext}),
        .rst_n  (rst_n),
        .want   (want),
        .live   (live),
        .clk_out(clk_mux)
    );

    clkdiv_core #(.HOLD(HOLD_CYC)) u_core (
        .clk      (clk_mux),
        .rst_n    (rst_n),
        .key_raw  (key_raw),
        .clk_div  (clk_div),
        .running_o(running),
        .restart_o(restart),
        .cnt_o    (cnt),
        .ratio_o  (ratio_cur)
    );

    assign clk_mon = clk_div;
endmodule

// File: rtl/clkdiv_checker.sv
// Module: assertion checker for clkdiv_top, attached by bind.
// Assumes it sees the selector enables and the divider state of the top.
module clkdiv_checker
    import cdiv_pkg::*;
(
    input logic            clk_ext,
    input logic            clk_mux,
    input logic            rst_n,
    input logic [NSRC-1:0] live,
    input logic            running,
    input logic            restart,
    input ratio_t          cnt,
    input ratio_t          ratio_cur,
    input logic            clk_div
);
    // R3: the selector never admits two sources at once.
    p_one_source_r3: assert property (@(posedge clk_ext) disable iff (!rst_n)
        $onehot0(live));

    // R9: a detected key change stops the divider on the next cycle.
    p_restart_stops_r9: assert property (@(posedge clk_mux) disable iff (!rst_n)
        restart |=> !running);

    // R9: while stopped, the divided output stays low.
    p_hold_low_r9: assert property (@(negedge clk_mux) disable iff (!rst_n)
        (!running && !$past(running)) |-> !clk_div);

    // R6: the phase counter stays inside the active ratio.
    p_cnt_range_r6: assert property (@(posedge clk_mux) disable iff (!rst_n)
        cnt < ratio_cur);
endmodule

bind clkdiv_top clkdiv_checker chk_i (
    .clk_ext  (clk_ext),
    .clk_mux  (clk_mux),
    .rst_n    (rst_n),
    .live     (live),
    .running  (running),
    .restart  (restart),
    .cnt      (cnt),
    .ratio_cur(ratio_cur),
    .clk_div  (clk_div)
);

// File: tb/clkdiv_top_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference for source and ratio, period measurement,
// and a pulse-width monitor that runs for the whole test.
module clkdiv_top_tb_top;
    logic       clk_ext = 0, clk_osc7 = 0, clk_osc9 = 0, clk_osc11 = 0, clk_sc = 0;
    logic       rst_n = 0;
    logic       int_sel = 0;
    logic [1:0] osc_pick = 0;
    logic [3:0] div_code = 0;
    logic       clk_div, clk_mon;

    int  checks = 0;
    int  errors = 0;
    int  narrow = 0;
    real last_t = 0.0;
    bit  seen = 0;

    always #2.5 clk_ext   = ~clk_ext;   // 200 MHz
    always #1.5 clk_osc7  = ~clk_osc7;
    always #2.0 clk_osc9  = ~clk_osc9;
    always #3.0 clk_osc11 = ~clk_osc11;
    always #3.5 clk_sc    = ~clk_sc;

    clkdiv_top dut_i (
        .clk_ext(clk_ext), .clk_osc7(clk_osc7), .clk_osc9(clk_osc9),
        .clk_osc11(clk_osc11), .clk_sc(clk_sc), .rst_n(rst_n),
        .int_sel(int_sel), .osc_pick(osc_pick), .div_code(div_code),
        .clk_div(clk_div), .clk_mon(clk_mon)
    );

    // Reference model: source period in ns (R1, R2).
    function automatic real ref_period(input logic isel, input logic [1:0] pk);
        real per[4] = '{3.0, 4.0, 6.0, 7.0};
        if (!isel) return 5.0;
        return per[pk];
    endfunction

    // Reference model: ratio (R4, R5).
    function automatic int ref_ratio(input logic isel, input logic [1:0] pk, input logic [3:0] c);
        int wide[16] = '{1, 2, 3, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192, 384};
        int nar[5]   = '{1, 2, 4, 8, 16};
        if (isel && pk == 2'd3) return (c < 5) ? nar[c] : 128;
        return wide[c];
    endfunction

    task automatic check(input bit ok, input string req, input real act, input real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
        end
    endtask

    // Pulse-width monitor (R3, R9): no phase narrower than the fastest half-period.
    always @(clk_div) begin
        if (rst_n && seen && ($realtime - last_t) < 1.49) narrow++;
        last_t = $realtime;
        seen   = 1;
    end

    task automatic run_cfg(input logic isel, input logic [1:0] pk, input logic [3:0] c);
        int    r    = ref_ratio(isel, pk, c);
        real   p    = ref_period(isel, pk);
        real   exph = r * p / 2.0;
        real   t0, t1, t2;
        string tag;
        tag = !isel ? "R1 R4" : (pk == 2'd3 ? "R2 R5" : "R2 R4");
        tag = {tag, (r == 1) ? " R8" : ((r % 2) != 0 ? " R7" : " R6")};
        int_sel = isel; osc_pick = pk; div_code = c;
        #100.3;
        @(posedge clk_div); t0 = $realtime;
        #0.2;
        check(clk_mon == 1'b1, {"R11 mon high ", tag}, real'(clk_mon), 1.0);
        @(negedge clk_div); t1 = $realtime;
        @(posedge clk_div); t2 = $realtime;
        check(((t1 - t0) - exph) < 0.01 && (exph - (t1 - t0)) < 0.01, {tag, " high"}, t1 - t0, exph);
        check(((t2 - t1) - exph) < 0.01 && (exph - (t2 - t1)) < 0.01, {tag, " low"}, t2 - t1, exph);
    endtask

    task automatic finish_run();
        check(narrow == 0, "R3 R9 narrow pulses", real'(narrow), 0.0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk_ext);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R10: outputs low in reset.
        #7.3;
        check(clk_div == 1'b0, "R10 reset div", real'(clk_div), 0.0);
        check(clk_mon == 1'b0, "R10 reset mon", real'(clk_mon), 0.0);
        #16.1 rst_n = 1;

        run_cfg(1'b0, 2'd0, 4'd0);   // ext /1
        run_cfg(1'b0, 2'd0, 4'd2);   // ext /3
        run_cfg(1'b0, 2'd3, 4'd5);   // ext /8, osc_pick ignored
        run_cfg(1'b1, 2'd0, 4'd1);   // osc7 /2
        run_cfg(1'b1, 2'd1, 4'd4);   // osc9 /6
        run_cfg(1'b1, 2'd2, 4'd15);  // osc11 /384
        run_cfg(1'b1, 2'd0, 4'd14);  // osc7 /192
        run_cfg(1'b1, 2'd1, 4'd10);  // osc9 /48
        run_cfg(1'b1, 2'd2, 4'd2);   // osc11 /3
        run_cfg(1'b1, 2'd0, 4'd0);   // osc7 /1
        run_cfg(1'b1, 2'd3, 4'd5);   // sc /128
        run_cfg(1'b1, 2'd3, 4'd3);   // sc /8
        run_cfg(1'b1, 2'd3, 4'd15);  // sc saturates at 128
        run_cfg(1'b1, 2'd3, 4'd0);   // sc /1
        run_cfg(1'b1, 2'd3, 4'd4);   // sc /16
        run_cfg(1'b0, 2'd1, 4'd7);   // ext /16
        run_cfg(1'b0, 2'd0, 4'd0);   // ext /1 before the reset test

        // R10: an asynchronous reset in the middle of a high phase forces the outputs low.
        @(posedge clk_div);
        #0.5 rst_n = 0;
        #0.3;
        check(clk_div == 1'b0, "R10 async div", real'(clk_div), 0.0);
        check(clk_mon == 1'b0, "R10 async mon", real'(clk_mon), 0.0);
        #20.2 rst_n = 1;
        run_cfg(1'b1, 2'd1, 4'd3);   // osc9 /4 after reset
        finish_run();
    end
endmodule